// File: doc/BRIEF.md
# Conditional Branch and Skip Resolver

This block works out where the program counter goes after a control-flow instruction. It supports four kinds of operation: a branch that depends on one status bit, a skip that depends on one test bit, an unconditional relative jump, and plain sequential flow. For each one it returns the next program counter, whether the flow was redirected, and how many cycles the instruction takes. The block does not fetch or decode. The decoder gives it the current program counter, the 8-bit status word, a 3-bit index that picks a status bit, a polarity bit, the signed offsets, the skip test bit, and the length of the instruction that follows.

Every input is sampled on the rising clock edge, and the three results are registered. The results therefore show one cycle after the operation is presented. A new operation can be presented on every cycle. Offsets are sign-extended to the program-counter width before the addition, and every sum wraps modulo 2^PC_W.

Top module: `branch_resolver`

## Requirements
- R1: While the asynchronous active-low reset `rstN` is asserted, `nextPc` is 0, `taken` is 0 and `cycles` is 0.
- R2: `flagSel` selects status bit 0 to 7, in this order: carry, zero, negative, overflow, signed, half-carry, transfer, interrupt-enable. A branch (`opKind`=2'b00) tests only the selected bit and ignores the other seven.
- R3: When `polarity`=1, a branch is taken if the selected bit is 1. When `polarity`=0, it is taken if the selected bit is 0.
- R4: A taken branch gives `nextPc` = PC + k + 1, where k is the 7-bit two's-complement `brOfs` (-64..63). It also gives `taken`=1 and `cycles`=2, so the target lies between PC-63 and PC+64.
- R5: A branch that is not taken gives `nextPc` = PC + 1, `taken`=0 and `cycles`=1.
- R6: A skip (`opKind`=2'b01) with `skipCond`=1 gives `taken`=1. If `nextTwoWords`=0 it gives PC + 2 and 2 cycles. If `nextTwoWords`=1 it gives PC + 3 and 3 cycles.
- R7: A skip with `skipCond`=0 gives PC + 1, `taken`=0 and `cycles`=1, whatever the value of `nextTwoWords`.
- R8: A relative jump (`opKind`=2'b10) is always taken. It gives PC + k + 1, where k is the 12-bit two's-complement `jmpOfs` (-2048..2047), and `cycles`=2.
- R9: Sequential flow (`opKind`=2'b11) gives PC + 1, `taken`=0 and `cycles`=1.
- R10: All program-counter sums wrap modulo 2^PC_W.
- R11: The outputs reflect the inputs sampled at the previous rising edge. Across all operations, `taken`=0 exactly when `cycles`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opKind | input | 2 | 00 branch, 01 skip, 10 jump, 11 sequential |
| pcIn | input | PC_W | Current program counter |
| statusIn | input | 8 | Status word |
| flagSel | input | 3 | Index of the status bit under test |
| polarity | input | 1 | 1: branch if bit set; 0: branch if bit clear |
| brOfs | input | BR_W | Branch offset, two's complement |
| jmpOfs | input | JMP_W | Jump offset, two's complement |
| skipCond | input | 1 | Skip condition already evaluated |
| nextTwoWords | input | 1 | The following instruction is two words long |
| nextPc | output | PC_W | Resolved next program counter |
| taken | output | 1 | Flow was redirected |
| cycles | output | 2 | Cycle count of the instruction |

## Verification
The assertions check four properties on every cycle. The taken flag always agrees with the cycle count. An untaken result always advances by exactly one. A branch never lands outside its 128-word window. A taken skip always moves by the distance that its cycle count implies. The assertions cannot show which status bit a given index reaches, whether the polarity is honoured, or the exact target value, including the wrap at both ends of the address space. Only the bench's vectors, its sweep over every index and polarity, and its directed reset cases can show these.

// File: rtl/brres_pkg.sv
package brres_pkg;
  typedef enum logic [1:0] {
    OP_BRANCH = 2'b00,
    OP_SKIP   = 2'b01,
    OP_JUMP   = 2'b10,
    OP_SEQ    = 2'b11
  } opKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic addBrOfs;   // target = pc + 1 + branch offset
    logic addJmpOfs;  // target = pc + 1 + jump offset
    logic stepTwo;    // skip over one-word instruction
    logic stepThree;  // skip over two-word instruction
    logic taken;      // flow redirected
    logic inBranch;   // operation is a status branch
  } stepCtl_t;
endpackage

// File: rtl/brres_ctrl.sv
module brres_ctrl
  import brres_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] opKind,
  input  logic [7:0] statusIn,
  input  logic [2:0] flagSel,
  input  logic       polarity,
  input  logic       skipCond,
  input  logic       nextTwoWords,
  output stepCtl_t   ctl
);
  opKind_e op;
  logic    flagBit;
  logic    brHit;

  assign op      = opKind_e'(opKind);
  assign flagBit = statusIn[flagSel];
  assign brHit   = (flagBit == polarity);

  always_comb begin
    ctl           = '0;
    ctl.inBranch  = (op == OP_BRANCH);
    ctl.addBrOfs  = (op == OP_BRANCH) && brHit;
    ctl.addJmpOfs = (op == OP_JUMP);
    ctl.stepTwo   = (op == OP_SKIP) && skipCond && !nextTwoWords;
    ctl.stepThree = (op == OP_SKIP) && skipCond && nextTwoWords;
    ctl.taken     = ctl.addBrOfs || ctl.addJmpOfs || ctl.stepTwo || ctl.stepThree;
  end

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.addBrOfs, ctl.addJmpOfs, ctl.stepTwo, ctl.stepThree}));
endmodule

// File: rtl/brres_dp.sv
module brres_dp
  import brres_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int BR_W  = 7,
  parameter int JMP_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  stepCtl_t         ctl,
  input  logic [PC_W-1:0]  pcIn,
  input  logic [BR_W-1:0]  brOfs,
  input  logic [JMP_W-1:0] jmpOfs,
  output logic [PC_W-1:0]  nextPc,
  output logic             taken,
  output logic [1:0]       cycles
);
  localparam int BR_EXT  = PC_W - BR_W;
  localparam int JMP_EXT = PC_W - JMP_W;
  localparam logic [PC_W-1:0] BR_BACK = PC_W'((1 << (BR_W - 1)) - 1);
  localparam logic [PC_W-1:0] BR_SPAN = PC_W'((1 << BR_W) - 1);

  logic [PC_W-1:0] brExt, jmpExt, ofsSel, stepSel, nextComb;
  logic [1:0]      cycComb;

  assign brExt  = {{BR_EXT{brOfs[BR_W-1]}}, brOfs};
  assign jmpExt = {{JMP_EXT{jmpOfs[JMP_W-1]}}, jmpOfs};

  always_comb begin
    if (ctl.addBrOfs)       ofsSel = brExt;
    else if (ctl.addJmpOfs) ofsSel = jmpExt;
    else                    ofsSel = '0;
    if (ctl.stepThree)      stepSel = PC_W'(3);
    else if (ctl.stepTwo)   stepSel = PC_W'(2);
    else                    stepSel = PC_W'(1);
    nextComb = pcIn + stepSel + ofsSel;
    if (!ctl.taken)         cycComb = 2'd1;
    else if (ctl.stepThree) cycComb = 2'd3;
    else                    cycComb = 2'd2;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextPc <= '0;
      taken  <= 1'b0;
      cycles <= 2'd0;
    end else begin
      nextPc <= nextComb;
      taken  <= ctl.taken;
      cycles <= cycComb;
    end
  end

  // observation state for the checks below
  logic            live, brPrev, skipPrev;
  logic [PC_W-1:0] pcPrev, pcDelta, brWin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      live     <= 1'b0;
      brPrev   <= 1'b0;
      skipPrev <= 1'b0;
      pcPrev   <= '0;
    end else begin
      live     <= 1'b1;
      brPrev   <= ctl.inBranch;
      skipPrev <= ctl.stepTwo || ctl.stepThree;
      pcPrev   <= pcIn;
    end
  end

  assign pcDelta = nextPc - pcPrev;
  assign brWin   = pcDelta + BR_BACK;

  // R11
  taken_cycles_chk: assert property (@(posedge clk) disable iff (!rstN)
    live |-> (taken == (cycles != 2'd1)));
  // R5
  untaken_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (live && !taken) |-> (pcDelta == PC_W'(1)));
  // R4
  branch_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (live && brPrev) |-> (brWin <= BR_SPAN));
  // R6
  skip_dist_chk: assert property (@(posedge clk) disable iff (!rstN)
    (live && skipPrev) |-> (taken && pcDelta == PC_W'(cycles) && cycles >= 2'd2));
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import brres_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int BR_W  = 7,
  parameter int JMP_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       opKind,
  input  logic [PC_W-1:0]  pcIn,
  input  logic [7:0]       statusIn,
  input  logic [2:0]       flagSel,
  input  logic             polarity,
  input  logic [BR_W-1:0]  brOfs,
  input  logic [JMP_W-1:0] jmpOfs,
  input  logic             skipCond,
  input  logic             nextTwoWords,
  output logic [PC_W-1:0]  nextPc,
  output logic             taken,
  output logic [1:0]       cycles
);
  stepCtl_t ctl;

  brres_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opKind(opKind), .statusIn(statusIn),
    .flagSel(flagSel), .polarity(polarity), .skipCond(skipCond),
    .nextTwoWords(nextTwoWords), .ctl(ctl)
  );

  brres_dp #(.PC_W(PC_W), .BR_W(BR_W), .JMP_W(JMP_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pcIn(pcIn), .brOfs(brOfs),
    .jmpOfs(jmpOfs), .nextPc(nextPc), .taken(taken), .cycles(cycles)
  );
endmodule

// File: tb/sim_branch_resolver.sv
`timescale 1ns/1ps
module sim_branch_resolver;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  opKind = 2'b11;
  logic [15:0] pcIn = '0;
  logic [7:0]  statusIn = '0;
  logic [2:0]  flagSel = '0;
  logic        polarity = 1'b0;
  logic [6:0]  brOfs = '0;
  logic [11:0] jmpOfs = '0;
  logic        skipCond = 1'b0;
  logic        nextTwoWords = 1'b0;
  logic [15:0] nextPc;
  logic        taken;
  logic [1:0]  cycles;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  branch_resolver u0 (
    .clk(clk), .rstN(rstN), .opKind(opKind), .pcIn(pcIn), .statusIn(statusIn),
    .flagSel(flagSel), .polarity(polarity), .brOfs(brOfs), .jmpOfs(jmpOfs),
    .skipCond(skipCond), .nextTwoWords(nextTwoWords),
    .nextPc(nextPc), .taken(taken), .cycles(cycles)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] pc;
    logic [7:0]  st;
    logic [2:0]  sel;
    logic        pol;
    logic [6:0]  bo;
    logic [11:0] jo;
    logic        sc;
    logic        two;
    logic [15:0] ePc;
    logic        eTk;
    logic [1:0]  eCy;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    // R4 zero flag set, branch-if-set, k=+5
    '{2'b00, 16'h0100, 8'h02, 3'd1, 1'b1, 7'h05, 12'h000, 1'b0, 1'b0, 16'h0106, 1'b1, 2'd2},
    // R5 same flag, branch-if-clear: not taken
    '{2'b00, 16'h0100, 8'h02, 3'd1, 1'b0, 7'h05, 12'h000, 1'b0, 1'b0, 16'h0101, 1'b0, 2'd1},
    // R4 carry clear, branch-if-clear, k=-63
    '{2'b00, 16'h0100, 8'h00, 3'd0, 1'b0, 7'h41, 12'h000, 1'b0, 1'b0, 16'h00C2, 1'b1, 2'd2},
    // R4 interrupt bit, k=+63 -> PC+64
    '{2'b00, 16'h0100, 8'h80, 3'd7, 1'b1, 7'h3F, 12'h000, 1'b0, 1'b0, 16'h0140, 1'b1, 2'd2},
    // R2 overflow at index 3, k=-1
    '{2'b00, 16'h0100, 8'h08, 3'd3, 1'b1, 7'h7F, 12'h000, 1'b0, 1'b0, 16'h0100, 1'b1, 2'd2},
    // R2 signed bit (index 4) clear while bit 3 set
    '{2'b00, 16'h0100, 8'h08, 3'd4, 1'b1, 7'h7F, 12'h000, 1'b0, 1'b0, 16'h0101, 1'b0, 2'd1},
    // R6 skip over one word
    '{2'b01, 16'h0200, 8'h00, 3'd0, 1'b0, 7'h00, 12'h000, 1'b1, 1'b0, 16'h0202, 1'b1, 2'd2},
    // R6 skip over two words
    '{2'b01, 16'h0200, 8'h00, 3'd0, 1'b0, 7'h00, 12'h000, 1'b1, 1'b1, 16'h0203, 1'b1, 2'd3},
    // R7 skip not met
    '{2'b01, 16'h0200, 8'hFF, 3'd0, 1'b1, 7'h00, 12'h000, 1'b0, 1'b1, 16'h0201, 1'b0, 2'd1},
    // R8 jump -2048
    '{2'b10, 16'h1000, 8'h00, 3'd0, 1'b0, 7'h00, 12'h800, 1'b0, 1'b0, 16'h0801, 1'b1, 2'd2},
    // R8 jump +2047
    '{2'b10, 16'h1000, 8'h00, 3'd0, 1'b0, 7'h00, 12'h7FF, 1'b0, 1'b0, 16'h1800, 1'b1, 2'd2},
    // R10 jump wraps at top
    '{2'b10, 16'hFFFF, 8'h00, 3'd0, 1'b0, 7'h00, 12'h000, 1'b0, 1'b0, 16'h0000, 1'b1, 2'd2},
    // R10 branch wraps below zero
    '{2'b00, 16'h0000, 8'h40, 3'd6, 1'b1, 7'h41, 12'h000, 1'b0, 1'b0, 16'hFFC2, 1'b1, 2'd2},
    // R9 sequential
    '{2'b11, 16'h0300, 8'hFF, 3'd0, 1'b1, 7'h3F, 12'h7FF, 1'b1, 1'b1, 16'h0301, 1'b0, 2'd1}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    opKind = v.op; pcIn = v.pc; statusIn = v.st; flagSel = v.sel; polarity = v.pol;
    brOfs = v.bo; jmpOfs = v.jo; skipCond = v.sc; nextTwoWords = v.two;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    check("R1 nextPc", 32'(nextPc), 0);
    check("R1 taken", 32'(taken), 0);
    check("R1 cycles", 32'(cycles), 0);
    rstN = 1'b1;

    // vector table, R11 one-cycle latency
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i]);
      @(negedge clk);
      check($sformatf("R11 vec%0d nextPc", i), 32'(nextPc), 32'(TBL[i].ePc));
      check($sformatf("R11 vec%0d taken", i), 32'(taken), 32'(TBL[i].eTk));
      check($sformatf("R11 vec%0d cycles", i), 32'(cycles), 32'(TBL[i].eCy));
    end

    // R2 / R3 sweep: every index, both polarities, bit alone and bit alone cleared
    for (int s = 0; s < 8; s++) begin
      for (int p = 0; p < 2; p++) begin
        for (int inv = 0; inv < 2; inv++) begin
          logic [7:0] st;
          logic       bitv;
          logic       expTk;
          st = 8'(1 << s);
          if (inv == 1) st = ~st;
          bitv  = (inv == 0);
          expTk = (bitv == p[0]);
          @(negedge clk);
          opKind = 2'b00; pcIn = 16'h4000; statusIn = st; flagSel = 3'(s);
          polarity = p[0]; brOfs = 7'h10;
          @(negedge clk);
          check($sformatf("R3 idx%0d pol%0d inv%0d taken", s, p, inv), 32'(taken), 32'(expTk));
          check($sformatf("R2 idx%0d pol%0d inv%0d pc", s, p, inv), 32'(nextPc),
                expTk ? 32'h4011 : 32'h4001);
        end
      end
    end

    // R1 reset while a taken jump is held
    @(negedge clk);
    opKind = 2'b10; pcIn = 16'h2222; jmpOfs = 12'h010;
    @(negedge clk);
    check("R8 pre-reset pc", 32'(nextPc), 32'h2233);
    rstN = 1'b0;
    #1;
    check("R1 async nextPc", 32'(nextPc), 0);
    check("R1 async taken", 32'(taken), 0);
    @(negedge clk);
    check("R1 held cycles", 32'(cycles), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 after reset pc", 32'(nextPc), 32'h2233);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule